// File: doc/BRIEF.md
# Received Packet Header Logger

This block is a debug trace buffer for a packet receive path. Each packet that the receive engine accepts is marked by a start-of-packet strobe on its first 64-bit beat. That first beat is written into a dual-port memory at the next free slot. Successive packets occupy consecutive slots. When the slot index reaches the configured depth it returns to zero and overwrites the oldest entries.

The host reads the trace through a separate read port while capture continues. It sees every 64-bit entry as two 32-bit dwords. The block also exposes the next slot index, the number of valid entries and a flag that reports older entries were overwritten. A clear strobe, driven by the host's write to a reset register, empties the log logically. A build-time parameter can remove the whole block, in which case every output is tied to zero.

Top module: `pkt_hdr_trace`

## Requirements
- R1: After reset, `next_slot`, `entry_count` and `wrapped` are all zero.
- R2: In a cycle with `rx_valid` and `rx_sop` both high and `log_clr` low, `rx_data` is written into slot `next_slot`. From the next cycle, `next_slot` is one higher.
- R3: A beat with `rx_sop` low, or `rx_sop` high without `rx_valid`, writes nothing and leaves `next_slot`, `entry_count` and every stored entry unchanged.
- R4: A capture in slot DEPTH-1 returns `next_slot` to 0 and sets `wrapped`. `wrapped` then stays set until a clear or reset, and later captures overwrite the oldest slots in order.
- R5: `entry_count` equals the number of captures since the last clear or reset, saturating at DEPTH.
- R6: A read with `rd_en` high at dword address A returns slot A>>1 on `rd_data` in the following cycle. Address bit 0 = 0 gives bits 31:0 and bit 0 = 1 gives bits 63:32. `rd_data` holds its value while `rd_en` is low.
- R7: A read of the slot being written in the same cycle returns the contents from before that write.
- R8: `log_clr` returns `next_slot`, `entry_count` and `wrapped` to zero in the next cycle. It takes priority over a capture in the same cycle, which is dropped. Stored entries are not erased.
- R9: With ENABLE = 0, all outputs are constant zero regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Beat is the first of a packet |
| rx_data | input | 64 | Receive beat data |
| log_clr | input | 1 | Host strobe that clears slot index, count and wrap flag |
| rd_en | input | 1 | Host read enable |
| rd_addr | input | $clog2(DEPTH)+1 | Host dword read address |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| next_slot | output | $clog2(DEPTH) | Slot the next captured header goes into |
| entry_count | output | $clog2(DEPTH+1) | Valid entries in the log |
| wrapped | output | 1 | Oldest entries have been overwritten |

## Verification
A four-slot instance receives ten packets with distinct headers, so the slot index wraps twice. After every packet, every valid entry is read back as both dwords. This separates a wrong slot, a swapped half and a missed overwrite.

Between packets, the bench sends non-first beats and strobes without valid that carry a junk marker. If that marker ever appears in a readback, the filtering has failed. Separate patterns cover:
- a capture and a read of the same slot in one cycle, which tells read-first from write-first behaviour;
- a clear arriving with a capture, which shows the clear wins and memory is kept;
- idle cycles after a read, which show the output holds.

A disabled instance driven by the same stimulus must show zeros throughout.

// File: rtl/pht_pkg.sv
package pht_pkg;

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
    } hdr_word_t;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_STORE = 2'd1,
        CAP_CLEAR = 2'd2
    } cap_op_t;

    function automatic logic [31:0] pick_dword(hdr_word_t w, logic upper);
        return upper ? w.hi : w.lo;
    endfunction

    function automatic cap_op_t decode_op(logic valid, logic sop, logic clr);
        if (clr)
            return CAP_CLEAR;
        else if (valid && sop)
            return CAP_STORE;
        else
            return CAP_IDLE;
    endfunction

endpackage

// File: rtl/pht_wr_ctrl.sv
module pht_wr_ctrl
    import pht_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic             clr,
    output logic             we,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] ptr,
    output logic [CNT_W-1:0] count,
    output logic             wrapped
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    cap_op_t op;
    logic    at_last;

    always_comb begin
        op      = decode_op(rx_valid, rx_sop, clr);
        at_last = (ptr == LAST_SLOT);
        we      = (op == CAP_STORE);
        waddr   = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst || op == CAP_CLEAR) begin
            ptr     <= '0;
            count   <= '0;
            wrapped <= 1'b0;
        end else if (op == CAP_STORE) begin
            ptr <= at_last ? '0 : ptr + 1'b1;
            if (at_last)
                wrapped <= 1'b1;
            if (count != FULL_CNT)
                count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pht_mem.sv
module pht_mem
    import pht_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic      clk,
    input  logic      we,
    input  logic [AW-1:0] waddr,
    input  hdr_word_t wdata,
    input  logic      re,
    input  logic [AW-1:0] raddr,
    output hdr_word_t rq
);

    hdr_word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store[waddr] <= wdata;
    end

    // Read-first: a same-cycle write is not visible on this port.
    always_ff @(posedge clk) begin
        if (re)
            rq <= store[raddr];
    end

endmodule

// File: rtl/pht_rd_port.sv
module pht_rd_port
    import pht_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH),
    localparam int RA_W = AW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic [RA_W-1:0] rd_addr,
    output logic            mem_re,
    output logic [AW-1:0]   mem_raddr,
    input  hdr_word_t       mem_q,
    output logic [31:0]     rd_data
);

    logic upper_q;

    always_comb begin
        mem_re    = rd_en;
        mem_raddr = rd_addr[RA_W-1:1];
        rd_data   = pick_dword(mem_q, upper_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            upper_q <= 1'b0;
        else if (rd_en)
            upper_q <= rd_addr[0];
    end

endmodule

// File: rtl/pkt_hdr_trace.sv
module pkt_hdr_trace
    import pht_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter bit ENABLE = 1'b1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int RA_W  = PTR_W + 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_sop,
    input  logic [63:0]      rx_data,
    input  logic             log_clr,
    input  logic             rd_en,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [31:0]      rd_data,
    output logic [PTR_W-1:0] next_slot,
    output logic [CNT_W-1:0] entry_count,
    output logic             wrapped
);

    generate
        if (ENABLE) begin : g_on
            logic             we;
            logic [PTR_W-1:0] waddr;
            logic             re;
            logic [PTR_W-1:0] raddr;
            hdr_word_t        q;

            pht_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
                .clk      (clk),
                .rst      (rst),
                .rx_valid (rx_valid),
                .rx_sop   (rx_sop),
                .clr      (log_clr),
                .we       (we),
                .waddr    (waddr),
                .ptr      (next_slot),
                .count    (entry_count),
                .wrapped  (wrapped)
            );

            pht_mem #(.DEPTH(DEPTH)) u_mem (
                .clk   (clk),
                .we    (we),
                .waddr (waddr),
                .wdata (hdr_word_t'(rx_data)),
                .re    (re),
                .raddr (raddr),
                .rq    (q)
            );

            pht_rd_port #(.DEPTH(DEPTH)) u_rd (
                .clk       (clk),
                .rst       (rst),
                .rd_en     (rd_en),
                .rd_addr   (rd_addr),
                .mem_re    (re),
                .mem_raddr (raddr),
                .mem_q     (q),
                .rd_data   (rd_data)
            );
        end else begin : g_off
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, rx_valid, rx_sop, rx_data,
                                     log_clr, rd_en, rd_addr};
            assign rd_data     = '0;
            assign next_slot   = '0;
            assign entry_count = '0;
            assign wrapped     = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pkt_hdr_trace_chk.sv
module pkt_hdr_trace_chk #(
    parameter int DEPTH  = 512,
    parameter bit ENABLE = 1'b1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_sop,
    input logic             log_clr,
    input logic             rd_en,
    input logic [31:0]      rd_data,
    input logic [PTR_W-1:0] next_slot,
    input logic [CNT_W-1:0] entry_count,
    input logic             wrapped
);

    generate
        if (ENABLE) begin : g_chk
            // R2
            slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
                (rx_valid && rx_sop && !log_clr) |=>
                    (int'(next_slot) == ((int'($past(next_slot)) == DEPTH - 1) ? 0
                                         : int'($past(next_slot)) + 1)));

            // R3
            beat_ignored_chk: assert property (@(posedge clk) disable iff (rst)
                (!(rx_valid && rx_sop) && !log_clr) |=>
                    ($stable(next_slot) && $stable(entry_count)));

            // R4
            wrap_rise_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(wrapped) |->
                    (int'($past(next_slot)) == DEPTH - 1 && next_slot == '0));

            // R4
            wrap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(wrapped) |-> $past(log_clr));

            // R5
            count_bound_chk: assert property (@(posedge clk) disable iff (rst)
                (int'(entry_count) <= DEPTH) && (!wrapped || int'(entry_count) == DEPTH));

            // R6
            rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
                !$past(rd_en) |-> $stable(rd_data));

            // R8
            clear_chk: assert property (@(posedge clk) disable iff (rst)
                log_clr |=> (next_slot == '0 && entry_count == '0 && !wrapped));
        end else begin : g_off
            // R9
            off_zero_chk: assert property (@(posedge clk)
                (rd_data == '0 && next_slot == '0 && entry_count == '0 && !wrapped));
        end
    endgenerate

endmodule

bind pkt_hdr_trace pkt_hdr_trace_chk #(.DEPTH(DEPTH), .ENABLE(ENABLE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_sop      (rx_sop),
    .log_clr     (log_clr),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .next_slot   (next_slot),
    .entry_count (entry_count),
    .wrapped     (wrapped)
);

// File: tb/pkt_hdr_trace_test.sv
module pkt_hdr_trace_test;

    localparam int D   = 4;
    localparam int PW  = $clog2(D);
    localparam int RAW = PW + 1;
    localparam int CW  = $clog2(D + 1);
    localparam logic [63:0] JUNK = 64'hBAD0_BAD0_BAD0_BAD0;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rx_valid = 1'b0;
    logic           rx_sop = 1'b0;
    logic [63:0]    rx_data = '0;
    logic           log_clr = 1'b0;
    logic           rd_en = 1'b0;
    logic [RAW-1:0] rd_addr = '0;

    logic [31:0]    rd_data, rd_data_off;
    logic [PW-1:0]  next_slot, next_slot_off;
    logic [CW-1:0]  entry_count, entry_count_off;
    logic           wrapped, wrapped_off;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] shadow [D];
    int          slot_m  = 0;
    int          count_m = 0;
    bit          wrap_m  = 1'b0;

    always #10 clk = ~clk;

    pkt_hdr_trace #(.DEPTH(D), .ENABLE(1'b1)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_data(rx_data), .log_clr(log_clr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .next_slot(next_slot), .entry_count(entry_count),
        .wrapped(wrapped)
    );

    pkt_hdr_trace #(.DEPTH(D), .ENABLE(1'b0)) uut_off (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_data(rx_data), .log_clr(log_clr), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_off), .next_slot(next_slot_off),
        .entry_count(entry_count_off), .wrapped(wrapped_off)
    );

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [63:0] hdr(int k);
        return {32'hC0DE_0000 | 32'(k), 32'h1234_0000 + 32'(k * 3)};
    endfunction

    task automatic capture(logic [63:0] d);
        rx_valid = 1'b1; rx_sop = 1'b1; rx_data = d;
        tick();
        rx_valid = 1'b0; rx_sop = 1'b0; rx_data = '0;
        shadow[slot_m] = d;
        if (slot_m == D - 1) wrap_m = 1'b1;
        slot_m = (slot_m + 1) % D;
        if (count_m < D) count_m++;
    endtask

    task automatic read_dw(int a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = RAW'(a);
        tick();
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic check_state(string req);
        check({req, " next_slot"}, next_slot, slot_m);
        check({req, " entry_count"}, entry_count, count_m);
        check({req, " wrapped"}, wrapped, wrap_m);
    endtask

    task automatic check_contents(string req);
        logic [31:0] v;
        for (int s = 0; s < count_m; s++) begin
            read_dw(2 * s, v);
            check({req, " low dword"}, v, shadow[s][31:0]);
            read_dw(2 * s + 1, v);
            check({req, " high dword"}, v, shadow[s][63:32]);
        end
    endtask

    task automatic check_off();
        check("R9 rd_data", rd_data_off, 0);
        check("R9 next_slot", next_slot_off, 0);
        check("R9 entry_count", entry_count_off, 0);
        check("R9 wrapped", wrapped_off, 0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check_state("R1");
        check_off();

        // R2 R3 R4 R5 R6: sweep through two full wraps
        for (int k = 0; k < 10; k++) begin
            rx_valid = 1'b1; rx_sop = 1'b0; rx_data = JUNK;
            tick();
            rx_valid = 1'b0; rx_sop = 1'b1;
            tick();
            rx_sop = 1'b0; rx_data = '0;
            check_state("R3");
            capture(hdr(k));
            check_state(k >= D - 1 ? "R4" : "R2");
            check("R5 count", entry_count, (k + 1 < D) ? k + 1 : D);
            check_contents("R6");
            check_off();
        end

        // R6 hold while rd_en low
        read_dw(3, v0);
        repeat (2) tick();
        check("R6 hold", rd_data, v0);

        // R7 read-first on a same-cycle write
        v0 = shadow[slot_m][31:0];
        rx_valid = 1'b1; rx_sop = 1'b1; rx_data = hdr(77);
        rd_en = 1'b1; rd_addr = RAW'(2 * slot_m);
        tick();
        rd_en = 1'b0; rx_valid = 1'b0; rx_sop = 1'b0;
        check("R7 old data", rd_data, v0);
        shadow[slot_m] = hdr(77);
        slot_m = (slot_m + 1) % D;
        read_dw(2 * ((slot_m + D - 1) % D), v);
        check("R7 new data", v, hdr(77) & 64'hFFFF_FFFF);

        // R8 clear beats a same-cycle capture; memory retained
        log_clr = 1'b1; rx_valid = 1'b1; rx_sop = 1'b1; rx_data = hdr(99);
        tick();
        log_clr = 1'b0; rx_valid = 1'b0; rx_sop = 1'b0;
        slot_m = 0; count_m = 0; wrap_m = 1'b0;
        check_state("R8");
        read_dw(0, v);
        check("R8 slot0 kept", v, shadow[0][31:0]);
        read_dw(1, v);
        check("R8 slot0 kept hi", v, shadow[0][63:32]);
        capture(hdr(5));
        check_state("R8 after");
        check_contents("R8 after");
        check_off();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule